// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block watches the register specifiers moving through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and decides, in the same cycle, how each operand must be sourced and whether the front of the pipeline must hold. It is purely combinational: the pipeline registers, register file and datapath muxes sit outside it and consume its outputs.

For the two execute-stage ALU operands it produces a 2-bit source select that picks the register-file value, the writeback result or the memory-stage result. The memory stage wins when both later stages hold a matching write, because it carries the younger value, and register zero is never bypassed. For the two decode-stage branch comparator operands it produces a 1-bit bypass from the memory stage only; a writeback-stage producer needs no bypass because the register file writes early in the cycle and reads late.

When a value cannot be bypassed in time, it raises one hold condition that freezes fetch and decode and injects a bubble into execute. Two causes feed it: a load in execute whose target is read by the instruction in decode, and a branch in decode whose operands are still being produced by the execute stage or loaded by the memory stage.

Top module: `hazard_unit`

## Requirements
- R1: `opa_sel_ex` is 2'b10 (memory-stage result) whenever `src1_ex` is nonzero, equals `dest_mem`, and `regwr_mem` is 1, regardless of the writeback stage.
- R2: Otherwise `opa_sel_ex` is 2'b01 (writeback result) when `src1_ex` is nonzero, equals `dest_wb`, and `regwr_wb` is 1; in all remaining cases it is 2'b00 (register file).
- R3: `opb_sel_ex` obeys the same rules as R1 and R2 with `src2_ex` in place of `src1_ex`.
- R4: A specifier of 0 is never bypassed: `src1_ex`/`src2_ex` equal to 0 give select 2'b00, and `src1_id`/`src2_id` equal to 0 give bypass 0, whatever the later stages write.
- R5: `cmpa_byp_id` is 1 exactly when `src1_id` is nonzero, equals `dest_mem`, and `regwr_mem` is 1; `cmpb_byp_id` is the same check on `src2_id`; a writeback-stage match alone never sets either bit.
- R6: A load-use hold is raised when `ldres_ex` is 1 and either `src1_id` or `src2_id` equals `src2_ex` (the load's target specifier).
- R7: A branch hold is raised when `is_branch_id` is 1, `regwr_ex` is 1 and `dest_ex` equals `src1_id` or `src2_id`; without `is_branch_id` that match raises nothing.
- R8: A branch hold is raised when `is_branch_id` is 1, `ldres_mem` is 1 and `dest_mem` equals `src1_id` or `src2_id`.
- R9: `hold_fetch`, `hold_decode` and `bubble_exec` are always equal, each being the OR of the R6, R7 and R8 conditions, and a cycle in which several operands match raises the same single level.
- R10: With every input at 0, all selects are 2'b00, both bypass bits are 0 and no hold is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src1_id | input | REG_W | First source specifier of the decode-stage instruction |
| src2_id | input | REG_W | Second source specifier of the decode-stage instruction |
| src1_ex | input | REG_W | First source specifier of the execute-stage instruction |
| src2_ex | input | REG_W | Second source specifier of the execute-stage instruction (load target) |
| dest_ex | input | REG_W | Destination specifier of the execute-stage instruction |
| dest_mem | input | REG_W | Destination specifier of the memory-stage instruction |
| dest_wb | input | REG_W | Destination specifier of the writeback-stage instruction |
| regwr_ex | input | 1 | Execute-stage instruction writes a register |
| regwr_mem | input | 1 | Memory-stage instruction writes a register |
| regwr_wb | input | 1 | Writeback-stage instruction writes a register |
| ldres_ex | input | 1 | Execute-stage instruction is a load |
| ldres_mem | input | 1 | Memory-stage instruction is a load |
| is_branch_id | input | 1 | Decode-stage instruction is a branch resolved in decode |
| opa_sel_ex | output | 2 | First ALU operand source: 00 register file, 01 writeback, 10 memory |
| opb_sel_ex | output | 2 | Second ALU operand source, same encoding |
| cmpa_byp_id | output | 1 | First comparator operand taken from the memory stage |
| cmpb_byp_id | output | 1 | Second comparator operand taken from the memory stage |
| hold_fetch | output | 1 | Freeze the fetch-stage program counter |
| hold_decode | output | 1 | Freeze the decode-stage pipeline register |
| bubble_exec | output | 1 | Clear the execute-stage pipeline register |

## Verification
Directed instruction sequences pin down each rule in isolation: a producer in both memory and writeback stages separates the priority order from a plain match, a writeback-only producer shows that decode bypassing ignores that stage, register zero as both source and destination shows the zero guard, and a register-writing non-branch in execute shows that the branch hold depends on the branch flag. A long pseudo-random sweep then draws every specifier from a four-register space, so that equalities between stages are frequent, and toggles all six flags, comparing each output against values computed arithmetically from the requirements; this separates the load-use and both branch-hold causes when they occur singly and together.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Source of an execute-stage ALU operand; the datapath mux decodes this.
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } ex_src_e;

    typedef struct packed {
        ex_src_e sel_a;
        ex_src_e sel_b;
        logic    byp_a;
        logic    byp_b;
        logic    hold;
    } hz_ctl_t;

endpackage

// File: rtl/hazard_ex_sel.sv
module hazard_ex_sel
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dest_mem,
    input  logic             wen_mem,
    input  logic [REG_W-1:0] dest_wb,
    input  logic             wen_wb,
    output ex_src_e          sel
);
    logic live;
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        live    = (src != '0);
        hit_mem = live && wen_mem && (src == dest_mem);
        hit_wb  = live && wen_wb  && (src == dest_wb);
        if (hit_mem)     sel = SRC_MEM;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end
endmodule

// File: rtl/hazard_id_byp.sv
module hazard_id_byp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dest_mem,
    input  logic             wen_mem,
    output logic             byp
);
    always_comb begin
        byp = (src != '0) && wen_mem && (src == dest_mem);
    end
endmodule

// File: rtl/hazard_stall.sv
module hazard_stall #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src1_id,
    input  logic [REG_W-1:0] src2_id,
    input  logic [REG_W-1:0] load_dst_ex,
    input  logic             ldres_ex,
    input  logic             is_branch_id,
    input  logic [REG_W-1:0] dest_ex,
    input  logic             regwr_ex,
    input  logic [REG_W-1:0] dest_mem,
    input  logic             ldres_mem,
    output logic             hold
);
    logic load_use;
    logic br_ex;
    logic br_mem;

    always_comb begin
        load_use = ldres_ex &&
                   ((src1_id == load_dst_ex) || (src2_id == load_dst_ex));
        br_ex    = is_branch_id && regwr_ex &&
                   ((dest_ex == src1_id) || (dest_ex == src2_id));
        br_mem   = is_branch_id && ldres_mem &&
                   ((dest_mem == src1_id) || (dest_mem == src2_id));
        hold     = load_use || br_ex || br_mem;
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hazard_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_OPS = 2
) (
    input  logic [REG_W-1:0] src1_id,
    input  logic [REG_W-1:0] src2_id,
    input  logic [REG_W-1:0] src1_ex,
    input  logic [REG_W-1:0] src2_ex,
    input  logic [REG_W-1:0] dest_ex,
    input  logic [REG_W-1:0] dest_mem,
    input  logic [REG_W-1:0] dest_wb,
    input  logic             regwr_ex,
    input  logic             regwr_mem,
    input  logic             regwr_wb,
    input  logic             ldres_ex,
    input  logic             ldres_mem,
    input  logic             is_branch_id,
    output logic [1:0]       opa_sel_ex,
    output logic [1:0]       opb_sel_ex,
    output logic             cmpa_byp_id,
    output logic             cmpb_byp_id,
    output logic             hold_fetch,
    output logic             hold_decode,
    output logic             bubble_exec
);
    localparam int LAST_OP = NUM_OPS - 1;

    logic [REG_W-1:0] ex_src [NUM_OPS];
    logic [REG_W-1:0] id_src [NUM_OPS];
    ex_src_e          ex_sel [NUM_OPS];
    logic             id_byp [NUM_OPS];
    logic             hold_w;
    hz_ctl_t          hz_d;

    always_comb begin
        ex_src[0]       = src1_ex;
        ex_src[LAST_OP] = src2_ex;
        id_src[0]       = src1_id;
        id_src[LAST_OP] = src2_id;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hazard_ex_sel #(.REG_W(REG_W)) u_ex_sel (
            .src      (ex_src[g]),
            .dest_mem (dest_mem),
            .wen_mem  (regwr_mem),
            .dest_wb  (dest_wb),
            .wen_wb   (regwr_wb),
            .sel      (ex_sel[g])
        );
        hazard_id_byp #(.REG_W(REG_W)) u_id_byp (
            .src      (id_src[g]),
            .dest_mem (dest_mem),
            .wen_mem  (regwr_mem),
            .byp      (id_byp[g])
        );
    end

    hazard_stall #(.REG_W(REG_W)) u_stall (
        .src1_id      (src1_id),
        .src2_id      (src2_id),
        .load_dst_ex  (src2_ex),
        .ldres_ex     (ldres_ex),
        .is_branch_id (is_branch_id),
        .dest_ex      (dest_ex),
        .regwr_ex     (regwr_ex),
        .dest_mem     (dest_mem),
        .ldres_mem    (ldres_mem),
        .hold         (hold_w)
    );

    always_comb begin
        hz_d.sel_a = ex_sel[0];
        hz_d.sel_b = ex_sel[LAST_OP];
        hz_d.byp_a = id_byp[0];
        hz_d.byp_b = id_byp[LAST_OP];
        hz_d.hold  = hold_w;
    end

    assign opa_sel_ex  = hz_d.sel_a;
    assign opb_sel_ex  = hz_d.sel_b;
    assign cmpa_byp_id = hz_d.byp_a;
    assign cmpb_byp_id = hz_d.byp_b;
    assign hold_fetch  = hz_d.hold;
    assign hold_decode = hz_d.hold;
    assign bubble_exec = hz_d.hold;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] src1_id,
    input logic [REG_W-1:0] src2_id,
    input logic [REG_W-1:0] src1_ex,
    input logic [REG_W-1:0] src2_ex,
    input logic [REG_W-1:0] dest_ex,
    input logic [REG_W-1:0] dest_mem,
    input logic [REG_W-1:0] dest_wb,
    input logic             regwr_ex,
    input logic             regwr_mem,
    input logic             regwr_wb,
    input logic             ldres_ex,
    input logic             ldres_mem,
    input logic             is_branch_id,
    input logic [1:0]       opa_sel_ex,
    input logic [1:0]       opb_sel_ex,
    input logic             cmpa_byp_id,
    input logic             cmpb_byp_id,
    input logic             hold_fetch,
    input logic             hold_decode,
    input logic             bubble_exec
);
    always_comb begin
        // R1
        mem_prio_chk: assert (!((src1_ex != '0) && regwr_mem && (src1_ex == dest_mem))
                              || (opa_sel_ex == 2'b10));
        // R4
        zero_src_chk: assert (((src1_ex != '0) || (opa_sel_ex == 2'b00)) &&
                              ((src2_ex != '0) || (opb_sel_ex == 2'b00)) &&
                              ((src1_id != '0) || !cmpa_byp_id) &&
                              ((src2_id != '0) || !cmpb_byp_id));
        // R5
        dec_mem_only_chk: assert ((!cmpa_byp_id || (regwr_mem && src1_id == dest_mem)) &&
                                  (!cmpb_byp_id || (regwr_mem && src2_id == dest_mem)));
        // R6
        load_use_chk: assert (!(ldres_ex && ((src1_id == src2_ex) || (src2_id == src2_ex)))
                              || hold_fetch);
        // R8
        br_load_chk: assert (!(is_branch_id && ldres_mem &&
                               ((dest_mem == src1_id) || (dest_mem == src2_id)))
                             || bubble_exec);
        // R9
        hold_agree_chk: assert ((hold_fetch == hold_decode) && (hold_decode == bubble_exec));
        // R10
        quiet_chk: assert (!(!regwr_ex && !regwr_mem && !regwr_wb && !ldres_ex &&
                             !ldres_mem && !is_branch_id)
                           || (opa_sel_ex == 2'b00 && opb_sel_ex == 2'b00 &&
                               !cmpa_byp_id && !cmpb_byp_id && !hold_decode));
    end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [RW-1:0] src1_id, src2_id, src1_ex, src2_ex, dest_ex, dest_mem, dest_wb;
    logic regwr_ex, regwr_mem, regwr_wb, ldres_ex, ldres_mem, is_branch_id;
    logic [1:0] opa_sel_ex, opb_sel_ex;
    logic cmpa_byp_id, cmpb_byp_id, hold_fetch, hold_decode, bubble_exec;

    int checks = 0;
    int failures = 0;
    logic [31:0] lcg = 32'h1234_5678;

    hazard_unit #(.REG_W(RW)) uut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int s1d, input int s2d, input int s1e, input int s2e,
                         input int de, input int dm, input int dw,
                         input bit we, input bit wm, input bit ww,
                         input bit le, input bit lm, input bit bd);
        @(posedge clk);
        #2;
        src1_id = RW'(s1d); src2_id = RW'(s2d); src1_ex = RW'(s1e); src2_ex = RW'(s2e);
        dest_ex = RW'(de); dest_mem = RW'(dm); dest_wb = RW'(dw);
        regwr_ex = we; regwr_mem = wm; regwr_wb = ww;
        ldres_ex = le; ldres_mem = lm; is_branch_id = bd;
        #5;
    endtask

    function automatic int exp_ex(input int s, input int dm, input bit wm,
                                  input int dw, input bit ww);
        if (s != 0 && s == dm && wm) return 2;
        if (s != 0 && s == dw && ww) return 1;
        return 0;
    endfunction

    function automatic int exp_id(input int s, input int dm, input bit wm);
        return (s != 0 && s == dm && wm) ? 1 : 0;
    endfunction

    function automatic int exp_hold(input int s1d, input int s2d, input int s2e,
                                    input int de, input int dm, input bit we,
                                    input bit le, input bit lm, input bit bd);
        bit lu, bx, bm;
        lu = le && (s1d == s2e || s2d == s2e);
        bx = bd && we && (de == s1d || de == s2d);
        bm = bd && lm && (dm == s1d || dm == s2d);
        return (lu || bx || bm) ? 1 : 0;
    endfunction

    task automatic check_hold(input string req, input int exp);
        check(req, int'(hold_fetch), exp);
        check(req, int'(hold_decode), exp);
        check(req, int'(bubble_exec), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: all inputs zero
        drive(0,0,0,0, 0,0,0, 0,0,0, 0,0,0);
        check("R10 sel_a", opa_sel_ex, 0);
        check("R10 sel_b", opb_sel_ex, 0);
        check("R10 byp_a", cmpa_byp_id, 0);
        check("R10 byp_b", cmpb_byp_id, 0);
        check_hold("R10 hold", 0);

        // R1: both later stages write r7, memory wins
        drive(0,0,7,3, 0,7,7, 0,1,1, 0,0,0);
        check("R1 mem priority", opa_sel_ex, 2);
        // R2: writeback-only producer
        drive(0,0,9,3, 0,4,9, 0,1,1, 0,0,0);
        check("R2 wb select", opa_sel_ex, 1);
        drive(0,0,9,3, 0,9,9, 0,0,0, 0,0,0);
        check("R2 no enable", opa_sel_ex, 0);
        // R3: second operand
        drive(0,0,1,12, 0,12,12, 0,1,1, 0,0,0);
        check("R3 mem", opb_sel_ex, 2);
        drive(0,0,1,12, 0,5,12, 0,1,1, 0,0,0);
        check("R3 wb", opb_sel_ex, 1);
        // R4: register zero
        drive(0,0,0,0, 0,0,0, 1,1,1, 0,0,0);
        check("R4 sel_a", opa_sel_ex, 0);
        check("R4 sel_b", opb_sel_ex, 0);
        check("R4 byp_a", cmpa_byp_id, 0);
        check("R4 byp_b", cmpb_byp_id, 0);
        // R5: decode bypass from memory only
        drive(6,6,0,0, 0,6,0, 0,1,0, 0,0,1);
        check("R5 byp_a mem", cmpa_byp_id, 1);
        check("R5 byp_b mem", cmpb_byp_id, 1);
        drive(6,8,0,0, 0,3,6, 0,1,1, 0,0,1);
        check("R5 wb ignored", cmpa_byp_id, 0);
        // R6: load-use on either decode source
        drive(2,4,0,4, 0,0,0, 0,0,0, 1,0,0);
        check_hold("R6 load-use src2", 1);
        drive(4,2,0,4, 0,0,0, 0,0,0, 1,0,0);
        check_hold("R6 load-use src1", 1);
        drive(2,3,0,4, 0,0,0, 0,0,0, 1,0,0);
        check_hold("R6 no match", 0);
        // R7: branch waits on execute producer, only with branch flag
        drive(10,11,0,0, 11,0,0, 1,0,0, 0,0,1);
        check_hold("R7 branch exec", 1);
        drive(10,11,0,0, 11,0,0, 1,0,0, 0,0,0);
        check_hold("R7 no branch", 0);
        // R8: branch waits on memory-stage load
        drive(13,14,0,0, 0,13,0, 0,1,0, 0,1,1);
        check_hold("R8 branch load", 1);
        check("R8 byp still flagged", cmpa_byp_id, 1);
        // R9: all sources match one producer, single hold level
        drive(4,4,0,4, 4,4,0, 1,1,0, 1,1,1);
        check_hold("R9 merged", 1);

        // Sweep over a four-register space: R1 R2 R3 R5 R9
        for (int i = 0; i < 30000; i++) begin
            int s1d, s2d, s1e, s2e, de, dm, dw;
            bit we, wm, ww, le, lm, bd;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            s1d = int'(lcg[31:30]); s2d = int'(lcg[29:28]);
            s1e = int'(lcg[27:26]); s2e = int'(lcg[25:24]);
            de  = int'(lcg[23:22]); dm  = int'(lcg[21:20]); dw = int'(lcg[19:18]);
            we = lcg[17]; wm = lcg[16]; ww = lcg[15];
            le = lcg[14]; lm = lcg[13]; bd = lcg[12];
            drive(s1d,s2d,s1e,s2e, de,dm,dw, we,wm,ww, le,lm,bd);
            check("R1 R2 sweep sel_a", opa_sel_ex, exp_ex(s1e, dm, wm, dw, ww));
            check("R3 sweep sel_b", opb_sel_ex, exp_ex(s2e, dm, wm, dw, ww));
            check("R5 sweep byp_a", cmpa_byp_id, exp_id(s1d, dm, wm));
            check("R5 sweep byp_b", cmpb_byp_id, exp_id(s2d, dm, wm));
            check_hold("R9 sweep hold",
                       exp_hold(s1d, s2d, s2e, de, dm, we, le, lm, bd));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule